// File: doc/BRIEF.md
# Timer with Shared Prescaler

An 8-bit free-running counter that advances either on an internal instruction tick (the system clock divided by four) or on a chosen edge of an external input. A single power-of-two prescaler sits between a count source and its consumer. It can be handed to the timer, dividing the timer's count events, or to a watchdog, dividing a watchdog base pulse train. Whichever side does not own the prescaler passes its events through undivided. The same 3-bit rate code gives a ratio twice as large on the timer side as on the watchdog side.

When the counter wraps from its top value to zero, a sticky overflow flag is set. An interrupt request follows when both a global enable and a timer enable are also set. Software reaches the counter, the mode register and the interrupt register through a simple single-cycle write port and a combinational read port. The watchdog side ends at a divided pulse output. Whatever counts those pulses and resets the chip lies outside the block.

Top module: `shared_div_timer`

## Requirements
- R1: After reset the mode register (address 1) reads 0x3F and the interrupt register (address 2) reads 0x00. Mode layout: bit0 external source, bit1 count on falling edge, bit2 prescaler owned by watchdog, bits 5:3 rate code. Interrupt layout: bit0 overflow flag, bit1 timer interrupt enable, bit2 global enable. Unused bits read 0.
- R2: The counter (address 0) keeps its value across a reset.
- R3: With the internal source selected and the prescaler owned by the watchdog, the counter advances by exactly one every 4 clock cycles.
- R4: With the prescaler owned by the timer, rate code k makes the counter advance once per 2^(k+1) source events.
- R5: With the prescaler owned by the watchdog, rate code k gives one watchdog output pulse per 2^k watchdog input pulses, counted from the last prescaler clear.
- R6: With the prescaler owned by the timer, every watchdog input pulse appears on the watchdog output.
- R7: With the external source selected, the counter counts rising edges of the input when bit1 is 0 and falling edges when bit1 is 1; the other edge has no effect.
- R8: A wrap from 0xFF to 0x00 sets the overflow flag, which stays set until software writes bit0 of the interrupt register to 0.
- R9: The interrupt request is high exactly when the overflow flag, the timer interrupt enable and the global enable are all 1.
- R10: The prescaler count is cleared by any counter write and by any mode write that changes the ownership bit.
- R11: A counter write loads the written value and takes priority over an increment on the same edge; otherwise the counter only holds or advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extIn | input | 1 | External count input, asynchronous |
| wdtTickIn | input | 1 | Watchdog base pulse, one cycle wide |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 counter, 1 mode, 2 interrupt |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| irq | output | 1 | Timer interrupt request |
| wdtTickOut | output | 1 | Watchdog pulse after the prescaler or bypass |

## Verification
The assertions take for granted that the watchdog base pulse is never high for two cycles in a row. They also assume that every register write lasts one cycle, and that the external input, once synchronised, produces edges that are far enough apart to be seen one at a time. The stimulus holds each external level for four clocks, gives watchdog pulses as isolated single cycles and drives writes at the falling edge for exactly one cycle. Rate checks measure windows that are whole multiples of the tick period, so the free-running phase of the instruction tick cannot shift the expected count.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int CNT_W  = 8;               // timer counter width
  localparam int RATE_W = 3;               // rate code width
  localparam int PRE_W  = 1 << RATE_W;     // prescaler counter width (max ratio 2^PRE_W)
  localparam int MODE_W = RATE_W + 3;
  localparam int DATA_W = CNT_W;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_INT  = 2'd2;

  // mode register bit positions
  localparam int M_EXT  = 0;
  localparam int M_FALL = 1;
  localparam int M_WDT  = 2;
  localparam int M_RATE = 3;

  typedef struct packed {
    logic              srcEvent;   // one count event from the selected source
    logic              wdtIn;      // watchdog base pulse
    logic              preToWdt;   // prescaler owner
    logic [RATE_W-1:0] rate;
    logic              preClr;     // clear prescaler count
    logic              cntWe;      // load counter
    logic [CNT_W-1:0]  cntWdata;
  } strobeT;
endpackage

// File: rtl/sdt_ctrl.sv
module sdt_ctrl
  import sdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              extIn,
  input  logic              wdtIn,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              ovfSet,
  output strobeT            strb
);
  logic [1:0]        phase;
  logic              cycTick;
  logic [2:0]        syncQ;
  logic              riseEv, fallEv;
  logic [MODE_W-1:0] mode;
  logic              ovfFlag, ovfIe, gie;
  logic              cntWe, modeWe, intWe;

  assign cntWe  = regWe && (regAddr == ADDR_CNT);
  assign modeWe = regWe && (regAddr == ADDR_MODE);
  assign intWe  = regWe && (regAddr == ADDR_INT);

  // instruction tick: one clock in four
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) phase <= '0;
    else       phase <= phase + 2'd1;
  assign cycTick = (phase == 2'd3);

  // two-flop synchroniser plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], extIn};
  assign riseEv = syncQ[1] & ~syncQ[2];
  assign fallEv = ~syncQ[1] & syncQ[2];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)       mode <= '1;
    else if (modeWe) mode <= regWdata[MODE_W-1:0];

  // overflow set wins over a same-cycle software write
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      ovfFlag <= 1'b0;
      ovfIe   <= 1'b0;
      gie     <= 1'b0;
    end else begin
      if (ovfSet)     ovfFlag <= 1'b1;
      else if (intWe) ovfFlag <= regWdata[0];
      if (intWe) begin
        ovfIe <= regWdata[1];
        gie   <= regWdata[2];
      end
    end

  assign irq = ovfFlag & ovfIe & gie;

  always_comb begin
    strb.srcEvent = mode[M_EXT] ? (mode[M_FALL] ? fallEv : riseEv) : cycTick;
    strb.wdtIn    = wdtIn;
    strb.preToWdt = mode[M_WDT];
    strb.rate     = mode[M_RATE +: RATE_W];
    strb.preClr   = cntWe || (modeWe && (regWdata[M_WDT] != mode[M_WDT]));
    strb.cntWe    = cntWe;
    strb.cntWdata = regWdata[CNT_W-1:0];
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CNT:  regRdata = cntVal;
      ADDR_MODE: regRdata[MODE_W-1:0] = mode;
      ADDR_INT:  regRdata[2:0] = {gie, ovfIe, ovfFlag};
      default:   regRdata = '0;
    endcase
  end

  // R3: instruction tick never lasts two cycles
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    cycTick |=> !cycTick);

  // R8: flag rises only from an overflow or a software write of 1
  p_flag_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(ovfSet) || $past(intWe && regWdata[0])));

  // R9: the request drops only when a write or reset changed the register
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(intWe));
endmodule

// File: rtl/sdt_dp.sv
module sdt_dp
  import sdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfSet,
  output logic             wdtOut
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             preIn, preTick, timInc;

  // owner side gets 2^(k+1) on the timer, 2^k on the watchdog
  always_comb
    if (strb.preToWdt) preMask = ~({PRE_W{1'b1}} << strb.rate);
    else               preMask = ~({PRE_W{1'b1}} << ({1'b0, strb.rate} + 4'd1));

  assign preIn   = strb.preToWdt ? strb.wdtIn : strb.srcEvent;
  assign preTick = preIn && ((preCnt & preMask) == preMask);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            preCnt <= '0;
    else if (strb.preClr) preCnt <= '0;
    else if (preIn)       preCnt <= preCnt + 1'b1;

  assign timInc = strb.preToWdt ? strb.srcEvent : preTick;
  assign wdtOut = strb.preToWdt ? preTick : strb.wdtIn;

  // counter deliberately has no reset: it survives reset with its value
  always_ff @(posedge clk)
    if (strb.cntWe)  cntVal <= strb.cntWdata;
    else if (timInc) cntVal <= cntVal + 1'b1;

  assign ovfSet = timInc && !strb.cntWe && (cntVal == '1);

  // R10: a clear request empties the prescaler on the next edge
  p_pre_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.preClr |=> (preCnt == '0));

  // R8: an overflow event leaves the counter at zero
  p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovfSet |=> (cntVal == '0));

  // R11: without a write the counter holds or steps by one
  p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntWe |=> ((cntVal == $past(cntVal)) || (cntVal == CNT_W'($past(cntVal) + 1'b1))));

  // R11: a write lands exactly
  p_cnt_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntWe |=> (cntVal == $past(strb.cntWdata)));

  // R5, R6: a watchdog output pulse always comes from an input pulse
  p_wdt_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    wdtOut |-> strb.wdtIn);
endmodule

// File: rtl/shared_div_timer.sv
module shared_div_timer
  import sdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              extIn,
  input  logic              wdtTickIn,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output logic              wdtTickOut
);
  strobeT           strb;
  logic [CNT_W-1:0] cntVal;
  logic             ovfSet;

  sdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .extIn(extIn), .wdtIn(wdtTickIn),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .cntVal(cntVal),
    .ovfSet(ovfSet), .strb(strb)
  );

  sdt_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cntVal(cntVal), .ovfSet(ovfSet), .wdtOut(wdtTickOut)
  );
endmodule

// File: tb/sim_shared_div_timer.sv
`timescale 1ns/1ps
module sim_shared_div_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extIn = 1'b0;
  logic       wdtTickIn = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       irq, wdtTickOut;

  int nChk = 0, nBad = 0, wdtSeen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shared_div_timer u0 (.*);

  always @(posedge clk) if (rstN && wdtTickOut) wdtSeen++;

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic extToggle(int n);
    for (int i = 0; i < n; i++) begin
      extIn = ~extIn; waitN(4);
    end
  endtask

  task automatic wdtPulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) wdtTickIn = 1'b1;
      @(negedge clk) wdtTickIn = 1'b0;
      waitN(1);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    int v, c0, c1, w0;
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    // R1 reset values
    rd(2'd1, v); check("R1 mode reset", v, 8'h3F);
    rd(2'd2, v); check("R1 int reset", v, 0);
    check("R9 irq after reset", irq, 0);

    // R2 counter survives reset (external falling source, input idle)
    wr(2'd0, 8'h5A);
    @(negedge clk) rstN = 1'b0;
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    rd(2'd0, v); check("R2 counter kept over reset", v, 8'h5A);

    // R3 internal source, watchdog owns prescaler: +1 per 4 clocks
    wr(2'd1, 8'h3C);
    waitN(8);
    rd(2'd0, c0); waitN(400); rd(2'd0, c1);
    check("R3 internal rate", (c1 - c0) & 8'hFF, 100);

    // R4 timer owns prescaler: sweep all rate codes
    for (int k = 0; k < 8; k++) begin
      wr(2'd1, 8'(k << 3));
      wr(2'd0, 8'h00);
      waitN(8);
      rd(2'd0, c0); waitN(8 << (k + 1)); rd(2'd0, c1);
      check($sformatf("R4 timer ratio code %0d", k), (c1 - c0) & 8'hFF, 2);
    end

    // R5 watchdog owns prescaler: sweep all rate codes
    for (int k = 0; k < 8; k++) begin
      wr(2'd1, 8'((k << 3) | 4));
      wr(2'd0, 8'h00);
      w0 = wdtSeen;
      wdtPulses(3 << k);
      check($sformatf("R5 watchdog ratio code %0d", k), wdtSeen - w0, 3);
    end

    // R6 timer owns prescaler: watchdog pulses pass through
    wr(2'd1, 8'h38);
    w0 = wdtSeen;
    wdtPulses(5);
    check("R6 watchdog bypass", wdtSeen - w0, 5);

    // R7 external rising edges, no division
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h10);
    extToggle(20); waitN(6);
    rd(2'd0, v); check("R7 rising edges", v, 8'h10 + 10);
    // falling edges only
    wr(2'd1, 8'h07);
    wr(2'd0, 8'h20);
    extIn = 1'b1; waitN(6);
    rd(2'd0, v); check("R7 rising ignored in falling mode", v, 8'h20);
    extIn = 1'b0; waitN(6);
    rd(2'd0, v); check("R7 falling counted", v, 8'h21);
    // R4 on external source: code 1 divides by 4
    wr(2'd1, 8'h09);
    wr(2'd0, 8'h00);
    extToggle(16); waitN(6);
    rd(2'd0, v); check("R4 external divide by 4", v, 2);

    // R8 / R9 overflow flag and request
    wr(2'd2, 8'h06);
    wr(2'd1, 8'h3C);
    wr(2'd0, 8'hFE);
    rd(2'd0, v); check("R11 write lands exactly", v, 8'hFE);
    rd(2'd2, v); check("R8 flag clear before wrap", v & 1, 0);
    waitN(16);
    rd(2'd2, v); check("R8 flag set on wrap", v & 1, 1);
    check("R9 irq with all enables", irq, 1);
    waitN(100);
    rd(2'd2, v); check("R8 flag sticky", v & 1, 1);
    wr(2'd2, 8'h03);
    check("R9 irq off without global enable", irq, 0);
    wr(2'd2, 8'h07);
    check("R9 irq back on", irq, 1);
    wr(2'd2, 8'h06);
    rd(2'd2, v); check("R8 flag cleared by write 0", v & 1, 0);
    check("R9 irq off without flag", irq, 0);

    // R10 ownership change clears a partly filled prescaler
    wr(2'd1, 8'h38);
    waitN(500);
    wr(2'd1, 8'h3C);
    wr(2'd1, 8'h38);
    rd(2'd0, c0);
    waitN(1000); rd(2'd0, c1);
    check("R10 no early tick after owner swap", (c1 - c0) & 8'hFF, 0);
    waitN(40); rd(2'd0, c1);
    check("R10 tick after full period", (c1 - c0) & 8'hFF, 1);

    // R10 counter write clears the prescaler too
    waitN(500);
    wr(2'd0, 8'h40);
    waitN(1000); rd(2'd0, v);
    check("R10 no early tick after counter write", v, 8'h40);
    waitN(40); rd(2'd0, v);
    check("R10 tick after counter write period", v, 8'h41);

    // R11 write beats increments under fast counting
    wr(2'd1, 8'h3C);
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, 8'(8'h80 + i));
      rd(2'd0, v); check("R11 write priority", v, 8'h80 + i);
      waitN(i);
    end

    done = 1;
    finish_run();
  end
endmodule